// File: doc/BRIEF.md
# ATA Programmed-I/O Strobe Sequencer

This block produces the bus strobes for a single programmed-I/O transfer to an ATA device. A caller raises a one-cycle start request together with a direction flag and a flag that tells whether the target is the data register or any other task-file register. On acceptance the sequencer picks one of three 32-bit timing words and takes a private copy of it. It then walks through four timed phases: address setup, strobe active, hold, and end-of-cycle recovery. It finishes with a one-cycle completion pulse.

Each timing word packs four 8-bit phase counts, and each phase lasts its count plus one clock. Controllers built with a variant number above 1 have two extra fast timing words, one for each of the two devices on the cable. Those words are used only for data-register transfers, and the choice between them follows a device bit that is latched whenever the device/head register is written. Every other transfer, and every transfer on a variant-1 controller, runs on the compatible timing word. On reads, the bus data is captured on the clock edge that ends the strobe.

Top module: `pio_strobe_seq`

## Requirements
- R1: After synchronous reset, busy, addr_vld, rd_strobe, wr_strobe, data_oe and done are all low, rd_data is zero and the latched device bit is 0.
- R2: A timing word holds four counts: setup in bits 7:0, strobe in bits 15:8, hold in bits 23:16 and recovery in bits 31:24. After the clock edge that accepts start, addr_vld is high without a strobe for setup+1 cycles. A strobe is then high for strobe+1 cycles. addr_vld then stays high without a strobe for hold+1 cycles. Finally busy is high with addr_vld low for recovery+1 cycles.
- R3: A count of 0 gives a one-cycle phase and a count of 255 gives a 256-cycle phase.
- R4: On a read (is_write=0) only rd_strobe pulses. rd_data takes the value of bus_rd_data present at the clock edge that ends the strobe.
- R5: On a write (is_write=1) only wr_strobe pulses. data_oe is high exactly during the strobe and hold phases, and rd_data does not change.
- R6: done is high for exactly one cycle, in the cycle after the last recovery cycle, and busy is low in that cycle. A start presented during the done cycle is accepted at once.
- R7: A start request while busy is ignored. The running transfer keeps its phase lengths, and no further transfer follows it.
- R8: With CTRL_VARIANT greater than 1, a data-register transfer (is_data=1) uses tim_fast1 when the latched device bit is 1 and tim_fast0 when it is 0. Every other transfer uses tim_compat.
- R9: With CTRL_VARIANT equal to 1, every transfer uses tim_compat, whatever is_data and the device bit are.
- R10: The timing word is sampled only on the accepting edge. Changes to the timing inputs during a transfer do not alter its phase lengths.
- R11: The device bit takes dev_bit on a clock edge where dev_wr is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Transfer request, taken only while idle |
| is_write | input | 1 | 1 = write transfer, 0 = read transfer |
| is_data | input | 1 | 1 = target is the data register |
| dev_wr | input | 1 | Load enable for the device bit (device/head register write) |
| dev_bit | input | 1 | Device number to latch |
| tim_compat | input | 32 | Compatible timing word |
| tim_fast0 | input | 32 | Fast data timing word for device 0 |
| tim_fast1 | input | 32 | Fast data timing word for device 1 |
| bus_rd_data | input | DATA_W | Data from the ATA bus |
| busy | output | 1 | Transfer in progress |
| addr_vld | output | 1 | Address lines valid |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| data_oe | output | 1 | Write data output enable |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Captured read data |

## Verification
The bench builds two copies that share their inputs. The first uses CTRL_VARIANT=2 with a 16-bit data path, so per-device fast timing, device-bit latching and the choice between fast0 and fast1 can all be exercised. The second uses CTRL_VARIANT=1, which shows that a data-register transfer with the device bit set still falls back to the compatible word. Distinct counts in each word make every selection visible in the measured phase lengths. Words at 0 and 255 reach both ends of the phase counter.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

    localparam int PIO_CNT_W  = 8;
    localparam int PIO_WORD_W = 4 * PIO_CNT_W;

    typedef logic [PIO_CNT_W-1:0] pio_cnt_t;

    // Field order fixed: recovery high byte, setup low byte.
    typedef struct packed {
        pio_cnt_t recov;
        pio_cnt_t hold;
        pio_cnt_t strobe;
        pio_cnt_t setup;
    } pio_timing_t;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_RECOV  = 3'd4
    } pio_phase_e;

    // Terminal count of the phase currently running.
    function automatic pio_cnt_t phase_limit(input pio_timing_t tw, input pio_phase_e ph);
        pio_cnt_t lim;
        case (ph)
            PH_SETUP:  lim = tw.setup;
            PH_STROBE: lim = tw.strobe;
            PH_HOLD:   lim = tw.hold;
            PH_RECOV:  lim = tw.recov;
            default:   lim = '0;
        endcase
        return lim;
    endfunction

    // Phase that follows the given one once its count expires.
    function automatic pio_phase_e phase_after(input pio_phase_e ph);
        pio_phase_e nx;
        case (ph)
            PH_SETUP:  nx = PH_STROBE;
            PH_STROBE: nx = PH_HOLD;
            PH_HOLD:   nx = PH_RECOV;
            default:   nx = PH_IDLE;
        endcase
        return nx;
    endfunction

    function automatic logic phase_has_addr(input pio_phase_e ph);
        return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    endfunction

endpackage

// File: rtl/pio_timing_sel.sv
module pio_timing_sel
    import pio_seq_pkg::*;
#(
    parameter int CTRL_VARIANT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        dev_wr,
    input  logic        dev_bit,
    input  logic        is_data,
    input  pio_timing_t tim_compat,
    input  pio_timing_t tim_fast0,
    input  pio_timing_t tim_fast1,
    output pio_timing_t sel_word
);

    generate
        if (CTRL_VARIANT > 1) begin : g_fast
            logic dev_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    dev_q <= 1'b0;
                end else if (dev_wr) begin
                    dev_q <= dev_bit;
                end
            end

            always_comb begin
                if (!is_data) begin
                    sel_word = tim_compat;
                end else if (dev_q) begin
                    sel_word = tim_fast1;
                end else begin
                    sel_word = tim_fast0;
                end
            end

            // R11: without a load the latched device stays put
            a_r11_dev_hold: assert property (@(posedge clk) disable iff (rst)
                !dev_wr |=> $stable(dev_q));

            // R8: non-data accesses never pick a fast word
            a_r8_compat_for_regs: assert property (@(posedge clk) disable iff (rst)
                (!is_data && (tim_fast0 != tim_compat) && (tim_fast1 != tim_compat))
                    |-> (sel_word != tim_fast0) && (sel_word != tim_fast1));
        end else begin : g_compat
            assign sel_word = tim_compat;
        end
    endgenerate

endmodule

// File: rtl/pio_phase_ctr.sv
module pio_phase_ctr
    import pio_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  pio_cnt_t limit,
    output logic     last
);

    pio_cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == limit);

    // R3: the counter never runs past the phase limit (no wrap at 255)
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);

endmodule

// File: rtl/pio_seq_fsm.sv
module pio_seq_fsm
    import pio_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_write,
    input  pio_timing_t       sel_word,
    input  logic [DATA_W-1:0] bus_rd_data,
    input  logic              cnt_last,
    output pio_cnt_t          cnt_limit,
    output logic              cnt_clear,
    output logic              busy,
    output logic              addr_vld,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              data_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    pio_phase_e        ph_q;
    pio_timing_t       tw_q;
    logic              wr_q;
    logic              done_q;
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            tw_q   <= '0;
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            rd_q   <= '0;
        end else begin
            done_q <= (ph_q == PH_RECOV) && cnt_last;
            if (ph_q == PH_IDLE) begin
                if (start) begin
                    ph_q <= PH_SETUP;
                    tw_q <= sel_word;
                    wr_q <= is_write;
                end
            end else if (cnt_last) begin
                ph_q <= phase_after(ph_q);
                if ((ph_q == PH_STROBE) && !wr_q) begin
                    rd_q <= bus_rd_data;
                end
            end
        end
    end

    assign cnt_limit = phase_limit(tw_q, ph_q);
    assign cnt_clear = (ph_q == PH_IDLE) || cnt_last;

    assign busy      = (ph_q != PH_IDLE);
    assign addr_vld  = phase_has_addr(ph_q);
    assign rd_strobe = (ph_q == PH_STROBE) && !wr_q;
    assign wr_strobe = (ph_q == PH_STROBE) && wr_q;
    assign data_oe   = wr_q && ((ph_q == PH_STROBE) || (ph_q == PH_HOLD));
    assign done      = done_q;
    assign rd_data   = rd_q;

    // R4 / R5: one direction only
    a_r4_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(rd_strobe && wr_strobe));

    // R2: a strobe always sits inside the address-valid window
    a_r2_strobe_in_addr: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe || wr_strobe) |-> addr_vld);

    // R6: completion pulse lasts one cycle and is never seen while busy
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: the captured word cannot change while a transfer runs
    a_r10_word_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tw_q));

    // R4: read data is the bus value at the edge ending the strobe
    a_r4_capture: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_strobe) |-> (rd_data == $past(bus_rd_data)));

    // R5: writes drive data but never disturb the read register
    a_r5_oe_not_read: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !rd_strobe);
    a_r5_rd_kept: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> $stable(rd_data));

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq
    import pio_seq_pkg::*;
#(
    parameter int CTRL_VARIANT = 2,
    parameter int DATA_W       = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  is_write,
    input  logic                  is_data,
    input  logic                  dev_wr,
    input  logic                  dev_bit,
    input  logic [PIO_WORD_W-1:0] tim_compat,
    input  logic [PIO_WORD_W-1:0] tim_fast0,
    input  logic [PIO_WORD_W-1:0] tim_fast1,
    input  logic [DATA_W-1:0]     bus_rd_data,
    output logic                  busy,
    output logic                  addr_vld,
    output logic                  rd_strobe,
    output logic                  wr_strobe,
    output logic                  data_oe,
    output logic                  done,
    output logic [DATA_W-1:0]     rd_data
);

    pio_timing_t sel_word;
    pio_cnt_t    cnt_limit;
    logic        cnt_clear;
    logic        cnt_last;

    pio_timing_sel #(
        .CTRL_VARIANT(CTRL_VARIANT)
    ) u_sel (
        .clk       (clk),
        .rst       (rst),
        .dev_wr    (dev_wr),
        .dev_bit   (dev_bit),
        .is_data   (is_data),
        .tim_compat(pio_timing_t'(tim_compat)),
        .tim_fast0 (pio_timing_t'(tim_fast0)),
        .tim_fast1 (pio_timing_t'(tim_fast1)),
        .sel_word  (sel_word)
    );

    pio_phase_ctr u_ctr (
        .clk  (clk),
        .rst  (rst),
        .clear(cnt_clear),
        .limit(cnt_limit),
        .last (cnt_last)
    );

    pio_seq_fsm #(
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_write   (is_write),
        .sel_word   (sel_word),
        .bus_rd_data(bus_rd_data),
        .cnt_last   (cnt_last),
        .cnt_limit  (cnt_limit),
        .cnt_clear  (cnt_clear),
        .busy       (busy),
        .addr_vld   (addr_vld),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .data_oe    (data_oe),
        .done       (done),
        .rd_data    (rd_data)
    );

    // R7: start while busy never restarts the setup phase
    a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy || done));

endmodule

// File: tb/sim_pio_strobe_seq.sv
`timescale 1ns/1ps
module sim_pio_strobe_seq;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        start = 1'b0, is_write = 1'b0, is_data = 1'b0;
    logic        dev_wr = 1'b0, dev_bit = 1'b0;
    logic [31:0] tim_compat = 32'h17021C06;
    logic [31:0] tim_fast0  = 32'h17021C06;
    logic [31:0] tim_fast1  = 32'h17021C06;
    logic [15:0] bus_rd_data = 16'h0;
    bit          which = 1'b0;

    logic        b0, a0, r0, w0, o0, d0, b1, a1, r1, w1, o1, d1;
    logic [15:0] q0, q1;

    pio_strobe_seq #(.CTRL_VARIANT(2), .DATA_W(16)) u0 (
        .clk(clk), .rst(rst), .start(start && !which), .is_write(is_write), .is_data(is_data),
        .dev_wr(dev_wr), .dev_bit(dev_bit), .tim_compat(tim_compat), .tim_fast0(tim_fast0),
        .tim_fast1(tim_fast1), .bus_rd_data(bus_rd_data), .busy(b0), .addr_vld(a0),
        .rd_strobe(r0), .wr_strobe(w0), .data_oe(o0), .done(d0), .rd_data(q0));

    pio_strobe_seq #(.CTRL_VARIANT(1), .DATA_W(16)) u1 (
        .clk(clk), .rst(rst), .start(start && which), .is_write(is_write), .is_data(is_data),
        .dev_wr(dev_wr), .dev_bit(dev_bit), .tim_compat(tim_compat), .tim_fast0(tim_fast0),
        .tim_fast1(tim_fast1), .bus_rd_data(bus_rd_data), .busy(b1), .addr_vld(a1),
        .rd_strobe(r1), .wr_strobe(w1), .data_oe(o1), .done(d1), .rd_data(q1));

    wire        m_busy = which ? b1 : b0;
    wire        m_addr = which ? a1 : a0;
    wire        m_rd   = which ? r1 : r0;
    wire        m_wr   = which ? w1 : w0;
    wire        m_oe   = which ? o1 : o0;
    wire        m_done = which ? d1 : d0;
    wire [15:0] m_q    = which ? q1 : q0;

    int total = 0;
    int bad = 0;
    logic [15:0] bus_val = 16'h1234;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One transfer, measured phase by phase at falling edges.
    task automatic run_access(input bit wr, input bit dat, input logic [31:0] w,
                              input string req, input bit hold_start, input bit mid_change);
        int ns = 0, nst = 0, nh = 0, nr = 0, noe = 0, nbad = 0, guard = 0;
        bit seen = 1'b0;
        logic [15:0] exp_q;
        exp_q = m_q;
        start = 1'b1; is_write = wr; is_data = dat;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        check(m_busy === 1'b1 && m_done === 1'b0, "R6", "accepted at once", m_busy, 1);
        while (m_done !== 1'b1 && guard < 2000) begin
            if (m_rd || m_wr) begin
                nst++; seen = 1'b1;
                if ((m_rd && wr) || (m_wr && !wr)) nbad++;
            end else if (m_addr) begin
                if (seen) nh++; else ns++;
            end else if (m_busy) begin
                nr++;
            end
            if (m_oe) noe++;
            bus_val = bus_val * 16'd5 + 16'd3;
            bus_rd_data = bus_val;
            if (m_rd) exp_q = bus_val;
            if (mid_change && guard == 1) begin
                tim_compat ^= 32'h0303_0303; tim_fast0 ^= 32'h0303_0303; tim_fast1 ^= 32'h0303_0303;
            end
            guard++;
            @(negedge clk);
        end
        if (hold_start) start = 1'b0;
        if (mid_change) begin
            tim_compat ^= 32'h0303_0303; tim_fast0 ^= 32'h0303_0303; tim_fast1 ^= 32'h0303_0303;
        end
        check(guard < 2000, req, "transfer completes", guard, 0);
        check(m_busy === 1'b0, "R6", "idle in done cycle", m_busy, 0);
        check(ns  == int'(w[7:0])   + 1, req, "setup length",    ns,  int'(w[7:0]) + 1);
        check(nst == int'(w[15:8])  + 1, req, "strobe length",   nst, int'(w[15:8]) + 1);
        check(nh  == int'(w[23:16]) + 1, req, "hold length",     nh,  int'(w[23:16]) + 1);
        check(nr  == int'(w[31:24]) + 1, req, "recovery length", nr,  int'(w[31:24]) + 1);
        check(nbad == 0, wr ? "R5" : "R4", "strobe direction", nbad, 0);
        check(noe == (wr ? int'(w[15:8]) + int'(w[23:16]) + 2 : 0), wr ? "R5" : "R4",
              "data_oe cycles", noe, wr ? int'(w[15:8]) + int'(w[23:16]) + 2 : 0);
        check(m_q === exp_q, wr ? "R5" : "R4", "rd_data", m_q, exp_q);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_dev(input bit v);
        dev_bit = v; dev_wr = 1'b1;
        @(negedge clk);
        dev_wr = 1'b0;
    endtask

    task automatic t_reset;
        check(b0 === 0 && a0 === 0 && r0 === 0 && w0 === 0 && o0 === 0 && d0 === 0,
              "R1", "outputs low after reset", {b0, a0, r0, w0, o0, d0}, 0);
        check(q0 === 16'h0, "R1", "rd_data zero", q0, 0);
        // device bit 0 after reset: data read picks fast0
        tim_fast0 = 32'h0102_0304; tim_fast1 = 32'h0506_0708;
        run_access(1'b0, 1'b1, 32'h0102_0304, "R1", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_default_read;
        tim_compat = 32'h17021C06;
        run_access(1'b0, 1'b0, 32'h17021C06, "R2", 1'b0, 1'b0);
        idle(2);
        run_access(1'b0, 1'b0, 32'h17021C06, "R4", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_write;
        tim_compat = 32'h0305_0702;
        run_access(1'b1, 1'b0, 32'h0305_0702, "R5", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_extremes;
        tim_compat = 32'h0000_0000;
        run_access(1'b1, 1'b0, 32'h0000_0000, "R3", 1'b0, 1'b0);
        idle(2);
        tim_compat = 32'hFF00_FF00;
        run_access(1'b0, 1'b0, 32'hFF00_FF00, "R3", 1'b0, 1'b0);
        idle(2);
        tim_compat = 32'h00FF_00FF;
        run_access(1'b1, 1'b0, 32'h00FF_00FF, "R3", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_select;
        tim_compat = 32'h0201_0403;
        tim_fast0  = 32'h0102_0304;
        tim_fast1  = 32'h0506_0708;
        set_dev(1'b0);
        run_access(1'b0, 1'b1, 32'h0102_0304, "R8", 1'b0, 1'b0);
        idle(2);
        set_dev(1'b1);
        run_access(1'b0, 1'b1, 32'h0506_0708, "R8", 1'b0, 1'b0);
        idle(2);
        run_access(1'b1, 1'b1, 32'h0506_0708, "R8", 1'b0, 1'b0);
        idle(2);
        run_access(1'b1, 1'b0, 32'h0201_0403, "R8", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_dev_latch;
        set_dev(1'b1);
        dev_bit = 1'b0;
        idle(3);
        run_access(1'b0, 1'b1, 32'h0506_0708, "R11", 1'b0, 1'b0);
        idle(2);
        set_dev(1'b0);
        dev_bit = 1'b1;
        idle(3);
        run_access(1'b0, 1'b1, 32'h0102_0304, "R11", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_busy_start;
        tim_compat = 32'h0203_0405;
        run_access(1'b0, 1'b0, 32'h0203_0405, "R7", 1'b1, 1'b0);
        idle(1);
        check(m_busy === 1'b0, "R7", "no second transfer", m_busy, 0);
        idle(3);
        check(m_busy === 1'b0 && m_done === 1'b0, "R7", "stays idle", m_busy, 0);
    endtask

    task automatic t_mid_change;
        tim_compat = 32'h0402_0603;
        run_access(1'b1, 1'b0, 32'h0402_0603, "R10", 1'b0, 1'b1);
        idle(2);
        set_dev(1'b1);
        run_access(1'b0, 1'b1, 32'h0506_0708, "R10", 1'b0, 1'b1);
        idle(2);
    endtask

    task automatic t_back_to_back;
        tim_compat = 32'h0101_0201;
        run_access(1'b0, 1'b0, 32'h0101_0201, "R6", 1'b0, 1'b0);
        run_access(1'b1, 1'b0, 32'h0101_0201, "R6", 1'b0, 1'b0);
        idle(2);
    endtask

    task automatic t_variant1;
        tim_compat = 32'h0302_0504;
        tim_fast1  = 32'h0809_0A0B;
        set_dev(1'b1);
        idle(600);
        which = 1'b1;
        run_access(1'b0, 1'b1, 32'h0302_0504, "R9", 1'b0, 1'b0);
        idle(2);
        run_access(1'b1, 1'b1, 32'h0302_0504, "R9", 1'b0, 1'b0);
        idle(2);
        which = 1'b0;
    endtask

    bit finished = 1'b0;

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);
        t_reset;
        t_default_read;
        t_write;
        t_extremes;
        t_select;
        t_dev_latch;
        t_busy_start;
        t_mid_change;
        t_back_to_back;
        t_variant1;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule